// File: doc/BRIEF.md
# Card Command Response Status Evaluator

This block sits beside the command path of a memory-card host controller. When software issues a command by writing the command word, the block decodes that word. It judges the raw response the card returned, given as a 16-byte vector and a received byte count. From that it decides whether the command timed out, whether the card reported an error, and whether the command completed. The outcome is merged into a 16-bit sticky status register. The kept response bytes are packed into eight 16-bit response registers.

Software clears status bits by writing ones to them. An interrupt line is raised whenever a status bit is set and its matching bit in a 15-bit enable mask is also set. Serial signalling on the card bus and CRC checks are done elsewhere.

Top module: `cmdRspEval`

## Requirements
- R1: A command write is accepted only while `ctrlEnable` is high, and then `lastCmd` holds the written word. While `ctrlEnable` is low, a command write leaves `lastCmd`, `status` and `rspWords` unchanged.
- R2: If the command word has the init flag (bit 7) set and index bits 5:0 equal 0, only status bit 0 is set. The response registers stay zero.
- R3: The response type code sits in command bits 10:8 (1, 2, 3 and 6 carry a response). Codes 1, 3 and 6 need `rspLen` of at least 4, and code 2 needs 16. A shorter length sets status bit 7, does not set bit 0, and leaves the response registers zero.
- R4: For type 1, the card status is the big-endian word formed from bytes 0..3. Status bit 14 is set when that word has any of bits 31..26, 24..19 or 16 set. Bit 3 also counts when `akeCheckEn` is high. The same rule holds when the busy flag (bit 11) is set.
- R5: For type 3, status bit 12 is set when bit 31 of the big-endian response word (bit 7 of byte 0) is clear.
- R6: For type 6, status bit 14 is set when the 16-bit value {byte 2, byte 3} ANDed with 0xE008 is non-zero. Bytes 0 and 1 play no part.
- R7: Response byte pair k is packed as {byte 2k, byte 2k+1} into response register 7-k, where register i is `rspWords[16i+15:16i]`. Types 1, 3 and 6 keep only bytes 0..3 (registers 7 and 6), and the other registers read zero. Type 2 keeps all 16 bytes.
- R8: Type codes 0, 4, 5 and 7 carry no response. They never time out, set no error bit, leave the response registers zero and set status bit 0.
- R9: Without a timeout, command index 12 sets status bits 0 and 2. Any other index sets only bit 0.
- R10: Every accepted command write first clears all eight response registers, whatever they held.
- R11: Status bits are sticky. A status write clears each bit written as one. A bit set by a command in the same cycle stays set.
- R12: `irq` is high exactly when `status[14:0] & intMask` is non-zero. `intMask` is loaded by a mask write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ctrlEnable | input | 1 | Controller enable; command writes are ignored while low |
| cmdWrite | input | 1 | Command word write strobe |
| cmdWord | input | 16 | Command word (index, init, type, busy fields) |
| rspBytes | input | 128 | Raw response, byte i at bits 8i+7:8i |
| rspLen | input | 5 | Number of response bytes received (0..16) |
| akeCheckEn | input | 1 | Adds card status bit 3 to the type-1 error check |
| statClrWrite | input | 1 | Status write strobe |
| statClrData | input | 16 | Ones clear the matching status bits |
| maskWrite | input | 1 | Interrupt mask write strobe |
| maskData | input | 15 | New interrupt mask |
| status | output | 16 | Sticky status register |
| rspWords | output | 128 | Eight packed 16-bit response registers |
| lastCmd | output | 16 | Last accepted command word |
| intMask | output | 15 | Current interrupt mask |
| irq | output | 1 | Masked interrupt request |

## Verification
Each response type is driven with a length just under its threshold and with a length at or above it. This separates a timeout from completion. It also confirms that short types keep only four bytes, while filler bytes sit in the rest of the vector.

Card status words are tried with a single error bit set, with only non-error bits set, and with the optional bit 3 under both settings of `akeCheckEn`. This shows whether the mask is right bit by bit and not just non-zero.

For type 6, a vector with ones only in bytes 0 and 1 shows those bytes are excluded. Command 12 is run against another index to tell the extra completion bit apart. Status writes that collide with a command show which of the two wins.

// File: rtl/cmdRspPkg.sv
`timescale 1ns/1ps
package cmdRspPkg;
  localparam int STAT_W    = 16;
  localparam int RSP_BYTES = 16;
  localparam int RSP_WORDS = RSP_BYTES / 2;
  localparam int LEN_W     = $clog2(RSP_BYTES + 1);
  localparam int MASK_W    = STAT_W - 1;

  // status bit positions
  localparam int ST_DONE    = 0;
  localparam int ST_STOP    = 2;
  localparam int ST_TMO     = 7;
  localparam int ST_OCRBUSY = 12;
  localparam int ST_CARDERR = 14;

  // command word field positions
  localparam int CW_INIT = 7;
  localparam int CW_TYPE = 8;
  localparam int CW_BUSY = 11;

  localparam logic [31:0] SHORT_ERR_MASK = 32'hFDF9_0000;
  localparam logic [31:0] AUTH_ERR_BIT   = 32'h0000_0008;
  localparam logic [15:0] RCA_ERR_MASK   = 16'hE008;
  localparam logic [5:0]  STOP_IDX       = 6'd12;

  typedef enum logic [2:0] {
    CL_NONE, CL_SHORT, CL_SHORTBUSY, CL_LONG, CL_OCR, CL_RCA
  } rspClass_e;

  typedef struct packed {
    logic              fire;
    logic [STAT_W-1:0] setBits;
    logic              keepShort;
    logic              keepLong;
  } evalStrobe_t;
endpackage

// File: rtl/cmdRspCtrl.sv
`timescale 1ns/1ps
module cmdRspCtrl
  import cmdRspPkg::*;
#(
  parameter int LENW   = LEN_W,
  parameter int NBYTES = RSP_BYTES
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         ctrlEnable,
  input  logic         cmdWrite,
  input  logic [5:0]   cmdIdx,
  input  logic         cmdInit,
  input  logic [2:0]   cmdType,
  input  logic         cmdBusy,
  input  logic [31:0]  rspHead,
  input  logic [LENW-1:0] rspLen,
  input  logic         akeCheckEn,
  output evalStrobe_t  strobe
);
  localparam int SHORT_LEN = 4;

  rspClass_e   rspClass;
  logic [31:0] cardWord;
  logic [LENW-1:0] needLen;
  logic        timedOut;
  logic        errHit;
  logic        ocrBusyClr;
  logic        initShortcut;

  always_comb begin
    case (cmdType)
      3'd1:    rspClass = cmdBusy ? CL_SHORTBUSY : CL_SHORT;
      3'd2:    rspClass = CL_LONG;
      3'd3:    rspClass = CL_OCR;
      3'd6:    rspClass = CL_RCA;
      default: rspClass = CL_NONE;
    endcase
  end

  assign cardWord = {rspHead[7:0], rspHead[15:8], rspHead[23:16], rspHead[31:24]};
  assign initShortcut = cmdInit && (cmdIdx == 6'd0);

  always_comb begin
    case (rspClass)
      CL_NONE: needLen = '0;
      CL_LONG: needLen = LENW'(NBYTES);
      default: needLen = LENW'(SHORT_LEN);
    endcase
  end

  assign timedOut = (rspClass != CL_NONE) && (rspLen < needLen);

  always_comb begin
    errHit     = 1'b0;
    ocrBusyClr = 1'b0;
    if (!timedOut) begin
      case (rspClass)
        CL_SHORT, CL_SHORTBUSY:
          errHit = |(cardWord & (SHORT_ERR_MASK | (akeCheckEn ? AUTH_ERR_BIT : 32'h0)));
        CL_RCA:
          errHit = |(cardWord[15:0] & RCA_ERR_MASK);
        CL_OCR:
          ocrBusyClr = !cardWord[31];
        default: ;
      endcase
    end
  end

  always_comb begin
    strobe = '0;
    strobe.fire = cmdWrite && ctrlEnable;
    if (initShortcut) begin
      strobe.setBits[ST_DONE] = 1'b1;
    end else begin
      strobe.setBits[ST_CARDERR] = errHit;
      strobe.setBits[ST_OCRBUSY] = ocrBusyClr;
      if (timedOut) begin
        strobe.setBits[ST_TMO] = 1'b1;
      end else begin
        strobe.setBits[ST_DONE] = 1'b1;
        strobe.setBits[ST_STOP] = (cmdIdx == STOP_IDX);
        strobe.keepLong  = (rspClass == CL_LONG);
        strobe.keepShort = (rspClass != CL_LONG) && (rspClass != CL_NONE);
      end
    end
  end

  // R3: a timeout never reports completion nor keeps response bytes
  a_r3_timeout_excl: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fire && strobe.setBits[ST_TMO]) |->
      (!strobe.setBits[ST_DONE] && !strobe.keepShort && !strobe.keepLong));

  // R2: the init shortcut sets only the completion bit
  a_r2_init_only_done: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fire && cmdInit && cmdIdx == 6'd0) |->
      (strobe.setBits == 16'h0001 && !strobe.keepShort && !strobe.keepLong));
endmodule

// File: rtl/cmdRspData.sv
`timescale 1ns/1ps
module cmdRspData
  import cmdRspPkg::*;
#(
  parameter int SW     = STAT_W,
  parameter int NBYTES = RSP_BYTES,
  parameter int MW     = MASK_W,
  localparam int NWORDS = NBYTES / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  evalStrobe_t       strobe,
  input  logic [15:0]       cmdWord,
  input  logic [NBYTES*8-1:0] rspBytes,
  input  logic              statClrWrite,
  input  logic [SW-1:0]     statClrData,
  input  logic              maskWrite,
  input  logic [MW-1:0]     maskData,
  output logic [SW-1:0]     status,
  output logic [NWORDS*16-1:0] rspWords,
  output logic [15:0]       lastCmd,
  output logic [MW-1:0]     intMask,
  output logic              irq
);
  localparam int SHORT_WORDS = 2;

  logic [15:0] rspReg [NWORDS];
  logic [SW-1:0] clrBits;

  assign clrBits = statClrWrite ? statClrData : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      status <= '0;
    end else if (statClrWrite || strobe.fire) begin
      status <= (status & ~clrBits) | (strobe.fire ? strobe.setBits : '0);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              intMask <= '0;
    else if (maskWrite)     intMask <= maskData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              lastCmd <= '0;
    else if (strobe.fire)   lastCmd <= cmdWord;
  end

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    localparam int PAIR = NWORDS - 1 - w;
    localparam bit IN_SHORT = (PAIR < SHORT_WORDS);
    logic keepThis;
    assign keepThis = strobe.keepLong || (strobe.keepShort && IN_SHORT);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rspReg[w] <= '0;
      end else if (strobe.fire) begin
        rspReg[w] <= keepThis ? {rspBytes[16*PAIR +: 8], rspBytes[16*PAIR+8 +: 8]} : 16'h0;
      end
    end
    assign rspWords[16*w +: 16] = rspReg[w];
  end

  assign irq = |(status[MW-1:0] & intMask);

  // R10: an accepted command keeping no bytes leaves every response register zero
  a_r10_rsp_cleared: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fire && !strobe.keepShort && !strobe.keepLong) |=> (rspWords == '0));

  // R11: a status write with no command clears every bit written as one
  a_r11_w1c: assert property (@(posedge clk) disable iff (!rstN)
    (statClrWrite && !strobe.fire) |=> ((status & $past(statClrData)) == '0));

  // R12: with no write of any kind, status and interrupt hold
  a_r12_irq_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!statClrWrite && !strobe.fire && !maskWrite) |=> ($stable(status) && $stable(irq)));
endmodule

// File: rtl/cmdRspEval.sv
`timescale 1ns/1ps
module cmdRspEval
  import cmdRspPkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          ctrlEnable,
  input  logic          cmdWrite,
  input  logic [15:0]   cmdWord,
  input  logic [127:0]  rspBytes,
  input  logic [4:0]    rspLen,
  input  logic          akeCheckEn,
  input  logic          statClrWrite,
  input  logic [15:0]   statClrData,
  input  logic          maskWrite,
  input  logic [14:0]   maskData,
  output logic [15:0]   status,
  output logic [127:0]  rspWords,
  output logic [15:0]   lastCmd,
  output logic [14:0]   intMask,
  output logic          irq
);
  evalStrobe_t strobe;

  cmdRspCtrl #(.LENW(LEN_W), .NBYTES(RSP_BYTES)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .ctrlEnable (ctrlEnable),
    .cmdWrite   (cmdWrite),
    .cmdIdx     (cmdWord[5:0]),
    .cmdInit    (cmdWord[CW_INIT]),
    .cmdType    (cmdWord[CW_TYPE +: 3]),
    .cmdBusy    (cmdWord[CW_BUSY]),
    .rspHead    (rspBytes[31:0]),
    .rspLen     (rspLen),
    .akeCheckEn (akeCheckEn),
    .strobe     (strobe)
  );

  cmdRspData #(.SW(STAT_W), .NBYTES(RSP_BYTES), .MW(MASK_W)) data_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .cmdWord      (cmdWord),
    .rspBytes     (rspBytes),
    .statClrWrite (statClrWrite),
    .statClrData  (statClrData),
    .maskWrite    (maskWrite),
    .maskData     (maskData),
    .status       (status),
    .rspWords     (rspWords),
    .lastCmd      (lastCmd),
    .intMask      (intMask),
    .irq          (irq)
  );

  // R1: command writes while disabled change nothing
  a_r1_disabled_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrite && !ctrlEnable && !statClrWrite) |=>
      ($stable(status) && $stable(rspWords) && $stable(lastCmd)));
endmodule

// File: tb/cmdRspEval_tb_top.sv
`timescale 1ns/1ps
module cmdRspEval_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctrlEnable = 1'b0, cmdWrite = 1'b0, akeCheckEn = 1'b0;
  logic statClrWrite = 1'b0, maskWrite = 1'b0;
  logic [15:0] cmdWord = '0, statClrData = '0;
  logic [127:0] rspBytes = '0;
  logic [4:0] rspLen = '0;
  logic [14:0] maskData = '0;
  logic [15:0] status, lastCmd;
  logic [127:0] rspWords;
  logic [14:0] intMask;
  logic irq;

  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cmdRspEval dut_i (.*);

  task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] mkBytes(logic [7:0] b0, b1, b2, b3);
    logic [127:0] v;
    for (int i = 0; i < 16; i++) v[8*i +: 8] = 8'hA0 + 8'(i);
    v[7:0] = b0; v[15:8] = b1; v[23:16] = b2; v[31:24] = b3;
    return v;
  endfunction

  function automatic logic [127:0] expPack(logic [127:0] b, int keep);
    logic [127:0] r = '0;
    for (int k = 0; k < 8; k++)
      if (2*k+1 < keep) r[16*(7-k) +: 16] = {b[16*k +: 8], b[16*k+8 +: 8]};
    return r;
  endfunction

  function automatic logic [15:0] cw(int idx, int rtype, bit busy, bit init);
    return 16'(idx & 63) | (16'(init) << 7) | (16'(rtype & 7) << 8) | (16'(busy) << 11);
  endfunction

  task automatic issue(logic [15:0] w, logic [127:0] b, int len);
    @(negedge clk);
    cmdWord = w; rspBytes = b; rspLen = 5'(len); cmdWrite = 1'b1;
    @(negedge clk);
    cmdWrite = 1'b0;
  endtask

  task automatic clearStatus();
    @(negedge clk);
    statClrWrite = 1'b1; statClrData = 16'hFFFF;
    @(negedge clk);
    statClrWrite = 1'b0;
  endtask

  task automatic tReset();
    check("reset status", status, 0);
    check("reset rsp", rspWords, 0);
    check("reset irq", irq, 0);
  endtask

  task automatic tDisabled();
    ctrlEnable = 1'b0;
    issue(cw(17, 1, 0, 0), mkBytes(0, 0, 0, 0), 6);
    check("R1 disabled status", status, 0);
    check("R1 disabled lastCmd", lastCmd, 0);
    check("R1 disabled rsp", rspWords, 0);
    ctrlEnable = 1'b1;
  endtask

  task automatic tInit();
    issue(cw(0, 1, 0, 1), mkBytes(8'h80, 1, 2, 3), 16);
    check("R2 init status", status, 16'h0001);
    check("R2 init rsp", rspWords, 0);
    clearStatus();
  endtask

  task automatic tShortOk();
    logic [127:0] b = mkBytes(0, 0, 8'h09, 0);
    logic [15:0] w = cw(13, 1, 0, 0);
    issue(w, b, 6);
    check("R1 lastCmd", lastCmd, w);
    check("R9 plain done", status, 16'h0001);
    check("R7 short pack", rspWords, expPack(b, 4));
    clearStatus();
  endtask

  task automatic tShortErr();
    issue(cw(17, 1, 0, 0), mkBytes(8'h80, 0, 0, 0), 4);
    check("R4 bit31 error", status, 16'h4001);
    clearStatus();
    issue(cw(17, 1, 0, 0), mkBytes(8'h02, 8'h06, 0, 0), 4);   // bits 25,18,17
    check("R4 non-error bits", status, 16'h0001);
    clearStatus();
    issue(cw(7, 1, 1, 0), mkBytes(0, 8'h40, 0, 0), 4);        // busy, bit 22
    check("R4 busy variant error", status, 16'h4001);
    clearStatus();
    issue(cw(7, 1, 0, 0), mkBytes(0, 8'h01, 0, 0), 4);        // bit 16
    check("R4 bit16 error", status, 16'h4001);
    clearStatus();
    akeCheckEn = 1'b0;
    issue(cw(7, 1, 0, 0), mkBytes(0, 0, 0, 8'h08), 4);
    check("R4 auth bit off", status, 16'h0001);
    clearStatus();
    akeCheckEn = 1'b1;
    issue(cw(7, 1, 0, 0), mkBytes(0, 0, 0, 8'h08), 4);
    check("R4 auth bit on", status, 16'h4001);
    akeCheckEn = 1'b0;
    clearStatus();
  endtask

  task automatic tTimeout();
    issue(cw(17, 1, 0, 0), mkBytes(0, 0, 0, 0), 3);
    check("R3 short timeout", status, 16'h0080);
    check("R3 timeout rsp", rspWords, 0);
    clearStatus();
    issue(cw(2, 2, 0, 0), mkBytes(1, 2, 3, 4), 15);
    check("R3 long timeout", status, 16'h0080);
    clearStatus();
    issue(cw(3, 6, 0, 0), mkBytes(0, 0, 0, 0), 3);
    check("R3 rca timeout", status, 16'h0080);
    clearStatus();
    issue(cw(12, 1, 0, 0), mkBytes(0, 0, 0, 0), 2);
    check("R9 stop with timeout", status, 16'h0080);
    clearStatus();
  endtask

  task automatic tLong();
    logic [127:0] b = mkBytes(8'h11, 8'h22, 8'h33, 8'h44);
    issue(cw(2, 2, 0, 0), b, 16);
    check("R3 long ok status", status, 16'h0001);
    check("R7 long pack", rspWords, expPack(b, 16));
    issue(cw(5, 0, 0, 0), b, 16);
    check("R10 cleared after new cmd", rspWords, 0);
    clearStatus();
  endtask

  task automatic tOcr();
    issue(cw(41, 3, 0, 0), mkBytes(8'h80, 8'hFF, 0, 0), 4);
    check("R5 ready", status, 16'h0001);
    clearStatus();
    issue(cw(41, 3, 0, 0), mkBytes(8'h7F, 8'hFF, 0, 0), 4);
    check("R5 busy", status, 16'h1001);
    clearStatus();
  endtask

  task automatic tRca();
    issue(cw(3, 6, 0, 0), mkBytes(8'hFF, 8'hFF, 0, 0), 4);
    check("R6 high bytes ignored", status, 16'h0001);
    clearStatus();
    issue(cw(3, 6, 0, 0), mkBytes(0, 0, 8'h20, 0), 4);
    check("R6 bit13 error", status, 16'h4001);
    clearStatus();
    issue(cw(3, 6, 0, 0), mkBytes(0, 0, 0, 8'h08), 4);
    check("R6 auth error", status, 16'h4001);
    clearStatus();
  endtask

  task automatic tNone();
    issue(cw(9, 0, 0, 0), mkBytes(1, 2, 3, 4), 16);
    check("R8 type0 status", status, 16'h0001);
    check("R8 type0 rsp", rspWords, 0);
    clearStatus();
    issue(cw(9, 5, 0, 0), mkBytes(8'h80, 2, 3, 4), 0);
    check("R8 type5 status", status, 16'h0001);
    clearStatus();
  endtask

  task automatic tStop();
    issue(cw(12, 1, 0, 0), mkBytes(0, 0, 0, 0), 4);
    check("R9 stop done", status, 16'h0005);
    clearStatus();
  endtask

  task automatic tW1cIrq();
    issue(cw(17, 1, 0, 0), mkBytes(0, 0, 0, 0), 2);
    issue(cw(17, 1, 0, 0), mkBytes(0, 0, 0, 0), 4);
    check("R11 sticky", status, 16'h0081);
    @(negedge clk); maskWrite = 1'b1; maskData = 15'h0080;
    @(negedge clk); maskWrite = 1'b0;
    check("R12 irq on", irq, 1);
    @(negedge clk); statClrWrite = 1'b1; statClrData = 16'h0080;
    @(negedge clk); statClrWrite = 1'b0;
    check("R11 w1c", status, 16'h0001);
    check("R12 irq off", irq, 0);
    @(negedge clk);
    statClrWrite = 1'b1; statClrData = 16'hFFFF;
    cmdWord = cw(12, 0, 0, 0); cmdWrite = 1'b1;
    @(negedge clk);
    statClrWrite = 1'b0; cmdWrite = 1'b0;
    check("R11 set wins", status, 16'h0005);
    @(negedge clk); maskWrite = 1'b1; maskData = 15'h0004;
    @(negedge clk); maskWrite = 1'b0;
    check("R12 irq mask bit2", irq, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tDisabled();
    tInit();
    tShortOk();
    tShortErr();
    tTimeout();
    tLong();
    tOcr();
    tRca();
    tNone();
    tStop();
    tW1cIrq();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule